// File: doc/BRIEF.md
# Direct-Map Window Address Translator

This block is the first stage of address translation and sits in front of the page-table cache. Every request carries a virtual address, the privilege level (kernel or user), whether it is an instruction fetch, the two translation-mode bits (direct-address enable and paging enable) and a 32/64-bit flag. Four window configuration words are supplied alongside. The block picks one of three outcomes: the address is translated directly, without any page lookup; the address is rejected as malformed; or the address is handed on unchanged to the page-table cache.

Direct-address mode applies when direct-address enable is 1 and paging enable is 0. It passes the address through, truncated to the physical width. In every other mode the four windows are compared in ascending index order. Each window holds a kernel enable, a user enable, a virtual segment and, for 32-bit mode, a physical segment. The lowest-numbered window that is enabled for the current privilege and whose segment equals the top segment of the address wins. When no window matches, the bits just above the virtual address width must be a sign extension. An address that fails this test faults. An address that passes is forwarded.

The result is registered and appears one clock after the request, marked by a valid strobe.

Top module: `dmw_translate`

## Requirements
- R1: After reset, and in every cycle without a result, `res_valid` is 0 and `res_kind` is 3'b000. When `res_valid` is 1, `res_kind` has exactly one bit set. The encoding is bit 0 = direct translation, bit 1 = bad-address fault, bit 2 = forward to the page-table cache.
- R2: When `mode_da`=1 and `mode_pg`=0, the result is direct, with `res_addr` equal to the virtual address with bits at and above PA_W cleared. This holds whatever the windows hold and even when the address is not a sign extension. Any other combination of the two mode bits uses the window path.
- R3: A window takes part only when its enable bit for the requesting privilege is set. Kernel requests (`req_user`=0) test bit 0 and user requests test bit 3. No other bit of the word enables a window.
- R4: In 64-bit mode (`mode_32`=0), a window matches when its bits [63:60] equal address bits [63:60]. The result address is the virtual address with bits at and above VA_W cleared.
- R5: In 32-bit mode, a window matches when its bits [31:29] equal address bits [31:29]. The result address is {window bits [27:25], address bits [28:0]}, zero-extended to 64 bits.
- R6: When several windows match, the lowest index decides the result.
- R7: When no window matches and address bits [63:48] are neither all 0 nor all 1, the result is a fault, and `res_addr` holds the faulting virtual address.
- R8: When no window matches and address bits [63:48] are all 0 or all 1, the result is forward, with `res_addr` equal to the unmodified virtual address.
- R9: A request accepted with `req_valid`=1 produces `res_valid`=1 exactly one clock later. A cycle with `req_valid`=0 produces `res_valid`=0 one clock later.
- R10: `res_fetch_err` is 1 only for a fault on an instruction fetch (select the fetch address-error cause). It is 0 for a fault on a data access (memory address-error cause) and 0 for every non-fault result. `res_perm` ({read, write, execute} = bits 2..0) is 3'b111 on a direct result and 3'b000 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| req_fetch | input | 1 | 1 = instruction fetch |
| mode_da | input | 1 | Direct-address enable |
| mode_pg | input | 1 | Paging enable |
| mode_32 | input | 1 | 1 = 32-bit address mode |
| win_cfg | input | 256 | Four 64-bit window words, window 0 in bits [63:0] |
| res_valid | output | 1 | Result strobe |
| res_kind | output | 3 | One-hot outcome {forward, fault, direct} |
| res_addr | output | 64 | Physical address (direct) or virtual address (fault, forward) |
| res_perm | output | 3 | Granted {read, write, execute} |
| res_fetch_err | output | 1 | Fault cause: 1 = fetch, 0 = memory access |

## Verification
The bench targets the following corner cases:
- Direct-address mode applied to a non-canonical address must translate rather than fault. A design that checked canonical form first would fault here.
- The same address is sent under kernel and under user privilege. A design that tested the wrong enable bit would fault or forward where a hit is expected.
- In 32-bit mode, two windows both match, but their physical segments differ. A priority error would show up as the wrong top three address bits.
- The fault cause is checked separately for fetches and for data accesses. Addresses with all-ones and with all-zeros upper bits are checked for forwarding. A sign test at the wrong bit position would turn these into false faults.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

    localparam int DMW_XLEN = 64;
    localparam logic [2:0] PERM_RWX  = 3'b111;
    localparam logic [2:0] PERM_NONE = 3'b000;

    typedef enum logic [2:0] {
        RK_NONE    = 3'b000,
        RK_DIRECT  = 3'b001,
        RK_FAULT   = 3'b010,
        RK_FORWARD = 3'b100
    } res_kind_e;

    typedef struct packed {
        res_kind_e             kind;
        logic [DMW_XLEN-1:0]   addr;
        logic [2:0]            perm;
        logic                  fetch_err;
    } dmw_result_t;

    function automatic dmw_result_t mk_direct(input logic [DMW_XLEN-1:0] pa);
        dmw_result_t r;
        r.kind      = RK_DIRECT;
        r.addr      = pa;
        r.perm      = PERM_RWX;
        r.fetch_err = 1'b0;
        return r;
    endfunction

    function automatic dmw_result_t mk_fault(input logic [DMW_XLEN-1:0] va,
                                             input logic fetch);
        dmw_result_t r;
        r.kind      = RK_FAULT;
        r.addr      = va;
        r.perm      = PERM_NONE;
        r.fetch_err = fetch;
        return r;
    endfunction

    function automatic dmw_result_t mk_forward(input logic [DMW_XLEN-1:0] va);
        dmw_result_t r;
        r.kind      = RK_FORWARD;
        r.addr      = va;
        r.perm      = PERM_NONE;
        r.fetch_err = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/dmw_window_match.sv
module dmw_window_match
    import dmw_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int SEG64_W    = 4,
    parameter int SEG32_W    = 3,
    parameter int KEN_BIT    = 0,
    parameter int UEN_BIT    = 3,
    parameter int PSEG32_LSB = 25
) (
    input  logic [DMW_XLEN-1:0] cfg,
    input  logic [DMW_XLEN-1:0] va,
    input  logic                user,
    input  logic                is32,
    output logic                hit,
    output logic [DMW_XLEN-1:0] pa
);
    localparam int XLEN      = DMW_XLEN;
    localparam int HALF      = 32;
    localparam int SEG64_LSB = XLEN - SEG64_W;
    localparam int SEG32_LSB = HALF - SEG32_W;

    logic               en;
    logic               seg_eq;
    logic [SEG64_W-1:0] cfg_seg64, va_seg64;
    logic [SEG32_W-1:0] cfg_seg32, va_seg32, pseg32;
    logic [XLEN-1:0]    pa64, pa32;
    logic               bits_unused;

    assign en        = user ? cfg[UEN_BIT] : cfg[KEN_BIT];
    assign cfg_seg64 = cfg[XLEN-1:SEG64_LSB];
    assign va_seg64  = va[XLEN-1:SEG64_LSB];
    assign cfg_seg32 = cfg[HALF-1:SEG32_LSB];
    assign va_seg32  = va[HALF-1:SEG32_LSB];
    assign pseg32    = cfg[PSEG32_LSB+SEG32_W-1:PSEG32_LSB];

    assign seg_eq = is32 ? (cfg_seg32 == va_seg32) : (cfg_seg64 == va_seg64);
    assign hit    = en & seg_eq;

    assign pa64 = {{(XLEN-VA_W){1'b0}}, va[VA_W-1:0]};
    assign pa32 = {{(XLEN-HALF){1'b0}}, pseg32, va[SEG32_LSB-1:0]};
    assign pa   = is32 ? pa32 : pa64;

    assign bits_unused = ^{cfg, va};
endmodule

// File: rtl/dmw_first_hit.sv
module dmw_first_hit #(
    parameter int N = 4,
    parameter int W = 64
) (
    input  logic [N-1:0]        hit,
    input  logic [N-1:0][W-1:0] pa,
    output logic                any_hit,
    output logic [W-1:0]        sel_pa
);
    always_comb begin
        any_hit = |hit;
        sel_pa  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_pa = pa[i];
            end
        end
    end
endmodule

// File: rtl/dmw_canon_check.sv
module dmw_canon_check
    import dmw_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int EXT_W = 16
) (
    input  logic [DMW_XLEN-1:0] va,
    output logic                canon
);
    localparam int TOP = VA_W + EXT_W - 1;

    logic [EXT_W-1:0] ext;
    logic             va_unused;

    assign ext       = va[TOP:VA_W];
    assign canon     = (ext == {EXT_W{1'b0}}) || (ext == {EXT_W{1'b1}});
    assign va_unused = ^va;
endmodule

// File: rtl/dmw_translate.sv
module dmw_translate
    import dmw_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PA_W       = 48,
    parameter int NUM_WIN    = 4,
    parameter int SEG64_W    = 4,
    parameter int SEG32_W    = 3,
    parameter int EXT_W      = 16,
    parameter int KEN_BIT    = 0,
    parameter int UEN_BIT    = 3,
    parameter int PSEG32_LSB = 25
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [63:0]                 req_vaddr,
    input  logic                        req_user,
    input  logic                        req_fetch,
    input  logic                        mode_da,
    input  logic                        mode_pg,
    input  logic                        mode_32,
    input  logic [NUM_WIN*64-1:0]       win_cfg,
    output logic                        res_valid,
    output logic [2:0]                  res_kind,
    output logic [63:0]                 res_addr,
    output logic [2:0]                  res_perm,
    output logic                        res_fetch_err
);
    localparam int XLEN = DMW_XLEN;

    logic [NUM_WIN-1:0]           win_hit;
    logic [NUM_WIN-1:0][XLEN-1:0] win_pa;
    logic                         any_hit;
    logic [XLEN-1:0]              hit_pa;
    logic                         canon;
    logic [XLEN-1:0]              da_pa;
    dmw_result_t                  nxt, res_q;
    logic                         valid_q;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        dmw_window_match #(
            .VA_W      (VA_W),
            .SEG64_W   (SEG64_W),
            .SEG32_W   (SEG32_W),
            .KEN_BIT   (KEN_BIT),
            .UEN_BIT   (UEN_BIT),
            .PSEG32_LSB(PSEG32_LSB)
        ) u_win (
            .cfg (win_cfg[g*XLEN +: XLEN]),
            .va  (req_vaddr),
            .user(req_user),
            .is32(mode_32),
            .hit (win_hit[g]),
            .pa  (win_pa[g])
        );
    end

    dmw_first_hit #(.N(NUM_WIN), .W(XLEN)) u_pick (
        .hit    (win_hit),
        .pa     (win_pa),
        .any_hit(any_hit),
        .sel_pa (hit_pa)
    );

    dmw_canon_check #(.VA_W(VA_W), .EXT_W(EXT_W)) u_canon (
        .va   (req_vaddr),
        .canon(canon)
    );

    assign da_pa = {{(XLEN-PA_W){1'b0}}, req_vaddr[PA_W-1:0]};

    always_comb begin
        if (mode_da && !mode_pg) begin
            nxt = mk_direct(da_pa);
        end else if (any_hit) begin
            nxt = mk_direct(hit_pa);
        end else if (!canon) begin
            nxt = mk_fault(req_vaddr, req_fetch);
        end else begin
            nxt = mk_forward(req_vaddr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_valid;
            res_q   <= req_valid ? nxt : '0;
        end
    end

    assign res_valid     = valid_q;
    assign res_kind      = res_q.kind;
    assign res_addr      = res_q.addr;
    assign res_perm      = res_q.perm;
    assign res_fetch_err = res_q.fetch_err;
endmodule

// File: rtl/dmw_translate_chk.sv
module dmw_translate_chk #(
    parameter int PA_W = 48
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [63:0] req_vaddr,
    input logic        req_fetch,
    input logic        mode_da,
    input logic        mode_pg,
    input logic        res_valid,
    input logic [2:0]  res_kind,
    input logic [63:0] res_addr,
    input logic [2:0]  res_perm,
    input logic        res_fetch_err
);
    localparam logic [63:0] PA_MASK = {{(64-PA_W){1'b0}}, {PA_W{1'b1}}};

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);

    a_r1_kind_onehot: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($countones(res_kind) == 1));

    a_r1_idle_kind: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (res_kind == 3'b000));

    a_r2_da_direct: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode_da && !mode_pg) |=>
            (res_kind == 3'b001 && res_addr == ($past(req_vaddr) & PA_MASK)));

    a_r10_direct_perm: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 3'b001) |-> (res_perm == 3'b111));

    a_r10_other_perm: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind != 3'b001) |-> (res_perm == 3'b000));

    a_r8_forward_addr: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 3'b100) |-> (res_addr == $past(req_vaddr)));

    a_r10_fault_cause: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 3'b010) |-> (res_fetch_err == $past(req_fetch)));

    a_r10_nonfault_cause: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind != 3'b010) |-> !res_fetch_err);
endmodule

bind dmw_translate dmw_translate_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/dmw_translate_bench.sv
`timescale 1ns/1ps
module dmw_translate_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [63:0] req_vaddr;
    logic        req_user, req_fetch, mode_da, mode_pg, mode_32;
    logic [255:0] win_cfg;
    logic        res_valid;
    logic [2:0]  res_kind;
    logic [63:0] res_addr;
    logic [2:0]  res_perm;
    logic        res_fetch_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dmw_translate u_dmw_translate (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_user(req_user), .req_fetch(req_fetch), .mode_da(mode_da),
        .mode_pg(mode_pg), .mode_32(mode_32), .win_cfg(win_cfg),
        .res_valid(res_valid), .res_kind(res_kind), .res_addr(res_addr),
        .res_perm(res_perm), .res_fetch_err(res_fetch_err)
    );

    localparam logic [2:0] KD = 3'b001;
    localparam logic [2:0] KF = 3'b010;
    localparam logic [2:0] KW = 3'b100;

    // window 0: seg64 9, kernel only, seg32 0, pseg 0
    // window 1: seg64 8, user only,   seg32 0, pseg 0
    // window 2: seg64 A, both,        seg32 5, pseg 1
    // window 3: seg64 9, both,        seg32 0, pseg 7
    localparam logic [255:0] WIN_STD = {64'h9000_0000_0E00_0009,
                                        64'hA000_0000_A200_0009,
                                        64'h8000_0000_0000_0008,
                                        64'h9000_0000_0000_0001};

    typedef struct packed {
        logic [63:0] va;
        logic        user;
        logic        fetch;
        logic        da;
        logic        pg;
        logic        is32;
        logic [2:0]  kind;
        logic [63:0] addr;
        logic        ferr;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{64'h9000_0012_3456_7890, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, KD, 64'h0000_0012_3456_7890, 1'b0, 8'd4},  // R4
        '{64'h9000_0012_3456_7890, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, KD, 64'h0000_0012_3456_7890, 1'b0, 8'd3},  // R3
        '{64'h8000_0000_0000_1000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, KD, 64'h0000_0000_0000_1000, 1'b0, 8'd3},  // R3
        '{64'h8000_0000_0000_1000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, KF, 64'h8000_0000_0000_1000, 1'b0, 8'd7},  // R7
        '{64'h8000_0000_0000_1000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, KF, 64'h8000_0000_0000_1000, 1'b1, 8'd10}, // R10
        '{64'h0000_1234_5678_9000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, KW, 64'h0000_1234_5678_9000, 1'b0, 8'd8},  // R8
        '{64'hFFFF_8000_0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, KW, 64'hFFFF_8000_0000_0000, 1'b0, 8'd8},  // R8
        '{64'h8000_0000_0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, KD, 64'h0000_0000_0000_1000, 1'b0, 8'd2},  // R2
        '{64'h0000_0000_0000_2000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, KW, 64'h0000_0000_0000_2000, 1'b0, 8'd2},  // R2
        '{64'h0001_0000_0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, KF, 64'h0001_0000_0000_0000, 1'b1, 8'd7},  // R7
        '{64'h0000_0000_1234_5678, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, KD, 64'h0000_0000_1234_5678, 1'b0, 8'd6},  // R6
        '{64'h0000_0000_A000_1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, KD, 64'h0000_0000_2000_1234, 1'b0, 8'd5},  // R5
        '{64'h0000_0000_6000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, KW, 64'h0000_0000_6000_0000, 1'b0, 8'd8},  // R8
        '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, KD, 64'h0000_FFFF_FFFF_FFFF, 1'b0, 8'd2}   // R2
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [63:0] va, input logic user, input logic fetch,
                          input logic da, input logic pg, input logic is32);
        @(negedge clk);
        req_vaddr = va; req_user = user; req_fetch = fetch;
        mode_da = da; mode_pg = pg; mode_32 = is32; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_result(input string req, input logic [2:0] kind,
                                input logic [63:0] addr, input logic ferr);
        check({req, " valid"}, {63'd0, res_valid}, 64'd1);
        check({req, " kind"}, {61'd0, res_kind}, {61'd0, kind});
        check({req, " addr"}, res_addr, addr);
        check({req, " perm"}, {61'd0, res_perm}, (kind == KD) ? 64'd7 : 64'd0);
        check({req, " fetch_err"}, {63'd0, res_fetch_err}, {63'd0, ferr});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b1; req_vaddr = 64'h9000_0000_0000_0000;
        req_user = 1'b0; req_fetch = 1'b0; mode_da = 1'b0; mode_pg = 1'b1;
        mode_32 = 1'b0; win_cfg = WIN_STD;
        repeat (3) @(negedge clk);
        // R1: reset state despite an active request
        check("R1 reset valid", {63'd0, res_valid}, 64'd0);
        check("R1 reset kind", {61'd0, res_kind}, 64'd0);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 idle after reset", {63'd0, res_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].va, VECS[i].user, VECS[i].fetch, VECS[i].da, VECS[i].pg, VECS[i].is32);
            check_result($sformatf("R%0d vec%0d", VECS[i].tag, i),
                         VECS[i].kind, VECS[i].addr, VECS[i].ferr);
        end

        // R9: no request yields no result one cycle later
        @(negedge clk);
        check("R9 no request", {63'd0, res_valid}, 64'd0);
        check("R1 idle kind", {61'd0, res_kind}, 64'd0);

        // R3: windows with only bits 1 and 2 set never enable
        win_cfg = {4{64'h9000_0000_0000_0006}};
        do_req(64'h9000_0000_0000_4000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check_result("R3 kernel no enable", KF, 64'h9000_0000_0000_4000, 1'b0);
        do_req(64'h9000_0000_0000_4000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check_result("R3 user no enable", KF, 64'h9000_0000_0000_4000, 1'b1);

        // R6: in 32-bit mode window 2 wins over window 3 with a different segment
        win_cfg = {64'h0000_0000_0E00_0009, 64'h0000_0000_0200_0009,
                   64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000};
        do_req(64'h0000_0000_0000_0040, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check_result("R6 lowest index", KD, 64'h0000_0000_2000_0040, 1'b0);

        // R4: DA=0 PG=0 still uses windows
        win_cfg = WIN_STD;
        do_req(64'hA000_0000_0000_0010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check_result("R4 da0 pg0 window", KD, 64'h0000_0000_0000_0010, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule